// File: doc/BRIEF.md
# Shared-Basis Finite-Field Vector Scaler

This block multiplies one scalar from GF(2^M) by every element of an N-lane vector in the same field and returns N products. Each element is read as a polynomial in the primitive element alpha: bit k of the element is the coefficient of alpha^k. The scalar is therefore multiplied by each power alpha^0 .. alpha^(M-1) only once. Each lane then forms its product by XOR-ing the shared multiples that its own set bits select. Each multiply by alpha is a left shift followed by a conditional XOR with the field polynomial, so only AND/XOR logic is used and there is no integer multiplier or carry chain.

The block is a two-stage pipeline with fixed latency. Stage one registers the M shared multiples of the scalar, together with each lane's element. Stage two registers each lane's selected XOR sum. The input valid strobe is delayed alongside the data. A new vector can be accepted every cycle. The field size, the lane count and the reduction polynomial are elaboration-time parameters. They default to M=3, N=4 and x^3+x+1.

Top module: `gfvm_top`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after `in_valid` was sampled high, and the products on `out_prod` in that cycle belong to that input.
- R2: Lane i occupies bits [i*M +: M] of both `in_vec` and `out_prod`. Its product equals `in_scalar` times element i in GF(2^M), reduced by the polynomial parameter (default 4'b1011, x^3+x+1). Bit k of every operand is the coefficient of alpha^k.
- R3: An element with a single set bit k yields the scalar times alpha^k. In particular, element 1 returns the scalar unchanged.
- R4: A zero scalar or a zero element yields a zero product in that lane.
- R5: Lanes are independent: different elements in different lanes in the same cycle each produce their own correct product.
- R6: Inputs presented on consecutive cycles produce outputs on consecutive cycles, with no lost or repeated vectors.
- R7: While reset (`rst_n` low) is asserted, `out_valid` is 0 and `out_prod` is all zeros.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector and scalar are valid |
| in_scalar | input | M | Scalar multiplier |
| in_vec | input | N*M | Packed vector, lane i at [i*M +: M] |
| out_valid | output | 1 | Products are valid |
| out_prod | output | N*M | Packed products, lane i at [i*M +: M] |

## Verification
Two things happen in the same cycle when vectors are streamed back to back. A vector's shared multiples are being registered in stage one, while the previous vector's lane sums leave stage two. The bench drives all 64 scalar/element pairs with no gaps inside each scalar group, so any crosstalk between stages shows up as a wrong product. Zero and non-zero elements are also mixed across lanes in the same cycle. Each lane is compared against a bit-serial reference product computed in the bench.

// File: rtl/gfvm_pkg.sv
package gfvm_pkg;
    // Default field: GF(2^3), reduction polynomial x^3 + x + 1
    localparam int unsigned DEF_M    = 3;
    localparam int unsigned DEF_N    = 4;
    localparam int unsigned DEF_POLY = 11;
    // Pipeline depth from input to output
    localparam int unsigned LATENCY  = 2;
endpackage

// File: rtl/gfvm_basis_gen.sv
module gfvm_basis_gen #(
    parameter int unsigned M    = gfvm_pkg::DEF_M,
    parameter int unsigned POLY = gfvm_pkg::DEF_POLY
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [M-1:0]           scalar,
    output logic [M-1:0][M-1:0]    basis_q
);
    localparam logic [M:0] POLY_V = (M+1)'(POLY);

    function automatic logic [M-1:0] times_alpha(input logic [M-1:0] x);
        logic [M:0] w;
        w = {x, 1'b0};
        if (w[M]) begin
            w = w ^ POLY_V;
        end
        return w[M-1:0];
    endfunction

    logic [M-1:0][M-1:0] chain;
    logic                live;

    assign chain[0] = scalar;
    for (genvar k = 1; k < M; k++) begin : g_chain
        assign chain[k] = times_alpha(chain[k-1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            basis_q <= '0;
            live    <= 1'b0;
        end else begin
            basis_q <= chain;
            live    <= 1'b1;
        end
    end

    // A field has no zero divisors: a non-zero scalar keeps every multiple non-zero
    for (genvar k = 0; k < M; k++) begin : g_chk
        AST_BASIS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (live && $past(scalar) != '0) |-> (basis_q[k] != '0)); // R2
    end
endmodule

// File: rtl/gfvm_lane.sv
module gfvm_lane #(
    parameter int unsigned M = gfvm_pkg::DEF_M
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [M-1:0]           elem_in,
    input  logic [M-1:0][M-1:0]    basis,
    output logic [M-1:0]           prod_q
);
    logic [M-1:0] elem_q;
    logic [M-1:0] sel_sum;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_q <= '0;
        end else begin
            elem_q <= elem_in;
        end
    end

    always_comb begin
        sel_sum = '0;
        for (int k = 0; k < int'(M); k++) begin
            if (elem_q[k]) begin
                sel_sum = sel_sum ^ basis[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
        end else begin
            prod_q <= sel_sum;
        end
    end

    AST_ZERO_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_q == '0) |=> (prod_q == '0)); // R4

    AST_UNIT_ELEM: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_q == M'(1)) |=> (prod_q == $past(basis[0]))); // R3
endmodule

// File: rtl/gfvm_top.sv
module gfvm_top #(
    parameter int unsigned M    = gfvm_pkg::DEF_M,
    parameter int unsigned N    = gfvm_pkg::DEF_N,
    parameter int unsigned POLY = gfvm_pkg::DEF_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [M-1:0]     in_scalar,
    input  logic [N*M-1:0]   in_vec,
    output logic             out_valid,
    output logic [N*M-1:0]   out_prod
);
    logic [M-1:0][M-1:0] basis_q;
    logic                vld_s1;
    logic                vld_s2;
    logic [1:0]          age;

    gfvm_basis_gen #(.M(M), .POLY(POLY)) u_basis (
        .clk     (clk),
        .rst_n   (rst_n),
        .scalar  (in_scalar),
        .basis_q (basis_q)
    );

    for (genvar i = 0; i < N; i++) begin : g_lane
        gfvm_lane #(.M(M)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .elem_in (in_vec[i*M +: M]),
            .basis   (basis_q),
            .prod_q  (out_prod[i*M +: M])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_s1 <= 1'b0;
            vld_s2 <= 1'b0;
        end else begin
            vld_s1 <= in_valid;
            vld_s2 <= vld_s1;
        end
    end

    assign out_valid = vld_s2;

    // cycles since reset, saturating, for the history-based checks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(in_valid, 2)) |-> out_valid); // R1

    AST_BUBBLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && !$past(in_valid, 2)) |-> !out_valid); // R8

    AST_ZERO_SCALAR: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && $past(in_scalar, 2) == '0) |-> (out_prod == '0)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_prod == '0)); // R7
endmodule

// File: tb/gfvm_top_tb.sv
module gfvm_top_tb;
    localparam int M = 3;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [M-1:0]   in_scalar = '0;
    logic [N*M-1:0] in_vec = '0;
    logic           out_valid;
    logic [N*M-1:0] out_prod;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gfvm_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_scalar (in_scalar),
        .in_vec    (in_vec),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // bit-serial reference, x^3 + x + 1
    function automatic logic [2:0] ref_mul(input logic [2:0] a, input logic [2:0] b);
        logic [3:0] r;
        r = '0;
        for (int i = 2; i >= 0; i--) begin
            r = {r[2:0], 1'b0};
            if (r[3]) r = r ^ 4'b1011;
            if (b[i]) r = r ^ {1'b0, a};
        end
        return r[2:0];
    endfunction

    // input history, two stages deep
    logic           h1_v, h2_v;
    logic [M-1:0]   h1_s, h2_s;
    logic [N*M-1:0] h1_e, h2_e;

    always @(posedge clk) begin
        if (!rst_n) begin
            h1_v <= 1'b0; h2_v <= 1'b0;
            h1_s <= '0;   h2_s <= '0;
            h1_e <= '0;   h2_e <= '0;
        end else begin
            h1_v <= in_valid; h2_v <= h1_v;
            h1_s <= in_scalar; h2_s <= h1_s;
            h1_e <= in_vec;   h2_e <= h1_e;
        end
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (out_valid !== 1'b0 || out_prod !== '0) begin
                errors++;
                $display("FAIL R7 reset: valid=%b prod=%h expected 0/000", out_valid, out_prod);
            end
        end else if (!done) begin
            checks++;
            if (out_valid !== h2_v) begin
                errors++;
                $display("FAIL %s: out_valid=%b expected %b",
                         h2_v ? "R1 R6" : "R8", out_valid, h2_v);
            end
            if (h2_v) begin
                for (int i = 0; i < N; i++) begin
                    logic [2:0] el, exp_p, got;
                    el = h2_e[i*M +: M];
                    exp_p = ref_mul(h2_s, el);
                    got = out_prod[i*M +: M];
                    checks++;
                    if (got !== exp_p) begin
                        errors++;
                        if (h2_s == 0 || el == 0)
                            $display("FAIL R4 lane %0d: got %0d expected %0d", i, got, exp_p);
                        else if ((el & (el - 1)) == 0)
                            $display("FAIL R3 lane %0d: got %0d expected %0d", i, got, exp_p);
                        else
                            $display("FAIL R2 R5 lane %0d: got %0d expected %0d", i, got, exp_p);
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // exhaustive sweep: every scalar, every element in every lane
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 8; e++) begin
                @(negedge clk);
                in_valid  = 1'b1;
                in_scalar = 3'(s);
                for (int i = 0; i < N; i++) in_vec[i*M +: M] = 3'((e + 3*i) % 8);
            end
            @(negedge clk);
            in_valid = 1'b0;      // bubble, R8
            in_vec   = '1;
            in_scalar = 3'(7 - s);
        end
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule